// File: doc/BRIEF.md
# Scan Decimation Sample Gate

This block sits on a sample stream between an acquisition buffer and whatever consumes the samples. An acquisition runs from a single conversion pacer, so its scan period can only be an integer multiple of one full scan. The gate turns that uniform stream back into one scan per scan period. It counts accepted samples in chunks of N×(1+D), where N is the number of channels in a scan and D is the delay factor. It passes the first N samples of each chunk on unchanged and absorbs the rest. D equals the scan period divided by N conversion periods, minus one. Working out D is left to the block that configures the acquisition.

Both sides use a valid/ready handshake. A one-cycle `start` pulse marks the beginning of an acquisition. It clears the chunk position and captures the channel count and delay factor. Between starts those inputs are ignored. The position lives in registers and moves only when a sample is accepted. Bursts from the buffer can therefore stop and resume anywhere inside a chunk. A `scan_done` pulse marks the handover of the last channel of each forwarded scan.

Top module: `scan_decim_gate`

## Requirements
- R1: After reset, with no start seen yet, the block acts as N=1, D=0: every valid input sample appears at the output in the same cycle.
- R2: Inside a chunk, a sample at position 0 to N−1 is forwarded with its data unchanged and in arrival order. The output is valid in the same cycle the input is valid.
- R3: A sample at a position from N to N×(1+D)−1 is taken with `in_ready` high whatever `out_ready` is, and `out_valid` stays low for it.
- R4: The chunk position wraps to 0 after N×(1+D) accepted samples. A run of 8 accepted samples with N=2, D=1 forwards 4 samples and gives 2 `scan_done` pulses.
- R5: With D=0, every input sample is forwarded.
- R6: A cycle with no accepted sample leaves the chunk position unchanged. After any gap, the stream carries on from the position it had reached.
- R7: In the cycle `start` is high, `in_ready` and `out_valid` are both low and no sample is accepted. The next accepted sample takes position 0 under the newly captured configuration.
- R8: `cfg_chan_cnt` and `cfg_delay` only take effect in a cycle with `start` high. Changes at any other time have no effect.
- R9: When a sample to be forwarded is on the input and `out_ready` is low, `in_ready` is low, so the sample is held.
- R10: `scan_done` is high for exactly those cycles in which position N−1 of a chunk (the last channel of a forwarded scan) is accepted at the output.
- R11: `cfg_chan_cnt` is an unsigned count. The value 0 is captured as 1, and values above 16 are captured as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Acquisition start pulse; captures the configuration and clears the position |
| cfg_chan_cnt | input | 5 | Channels per scan, N (1..16) |
| cfg_delay | input | 16 | Delay factor D; skipped scans per kept scan |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 16 | Input sample |
| in_ready | output | 1 | Input sample accepted when high together with in_valid |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Output sample |
| out_ready | input | 1 | Sink ready |
| scan_done | output | 1 | Pulse on acceptance of the last sample of a forwarded scan |

## Verification
Some rules are checked on every cycle by properties. Discarded samples are always taken. Stalled forwarded samples hold the input. The start cycle blocks both sides. The position only moves on acceptance. The captured configuration stays fixed between starts. `scan_done` only fires on an output handshake. Whether the right positions are kept, and whether the chunk wraps at N×(1+D), can only be shown by the bench's scenarios. It runs a reference position model under random valid/ready patterns, sparse bursts, mid-chunk restarts and clamped channel counts, and compares forward and scan counts over an exact chunk.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

    localparam int CHAN_MAX = 16;
    localparam int CNT_W    = $clog2(CHAN_MAX + 1);
    localparam int IDX_W    = (CHAN_MAX > 1) ? $clog2(CHAN_MAX) : 1;
    localparam int DLY_W    = 16;

    // Captured acquisition configuration
    typedef struct packed {
        logic [CNT_W-1:0] nchan;
        logic [DLY_W-1:0] delay;
    } gate_cfg_t;

    // Position inside a chunk: channel within scan, scan within chunk
    typedef struct packed {
        logic [IDX_W-1:0] chan;
        logic [DLY_W-1:0] scan;
    } gate_pos_t;

    localparam gate_cfg_t CFG_RESET = '{nchan: CNT_W'(1), delay: '0};

    function automatic logic [CNT_W-1:0] clamp_chan(input logic [CNT_W-1:0] raw);
        if (raw == '0)
            return CNT_W'(1);
        if (raw > CNT_W'(CHAN_MAX))
            return CNT_W'(CHAN_MAX);
        return raw;
    endfunction

endpackage

// File: rtl/sdg_cfg_latch.sv
module sdg_cfg_latch
    import sdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] raw_nchan,
    input  logic [DLY_W-1:0] raw_delay,
    output gate_cfg_t        cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (start) begin
            cfg.nchan <= clamp_chan(raw_nchan);
            cfg.delay <= raw_delay;
        end
    end

endmodule

// File: rtl/sdg_pos_track.sv
module sdg_pos_track
    import sdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      advance,
    input  gate_cfg_t cfg,
    output gate_pos_t pos,
    output logic      keep,
    output logic      last
);

    logic scan_wrap;

    // Only the first scan slot of a chunk is forwarded
    assign keep      = (pos.scan == '0);
    assign last      = (CNT_W'(pos.chan) == (cfg.nchan - CNT_W'(1)));
    assign scan_wrap = (pos.scan == cfg.delay);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            pos <= '0;
        end else if (advance) begin
            if (last) begin
                pos.chan <= '0;
                pos.scan <= scan_wrap ? '0 : pos.scan + DLY_W'(1);
            end else begin
                pos.chan <= pos.chan + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/sdg_handshake.sv
module sdg_handshake (
    input  logic start,
    input  logic keep,
    input  logic last,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic advance,
    output logic scan_done
);

    // Forwarded samples follow the sink; discarded ones are always taken
    assign in_ready  = !start && (keep ? out_ready : 1'b1);
    assign out_valid = in_valid && keep && !start;
    assign advance   = in_valid && in_ready;
    assign scan_done = advance && keep && last;

endmodule

// File: rtl/scan_decim_gate.sv
module scan_decim_gate
    import sdg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  cfg_chan_cnt,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              scan_done
);

    gate_cfg_t cfg_q;
    gate_pos_t pos_q;
    logic      keep_w;
    logic      last_w;
    logic      adv_w;

    sdg_cfg_latch u_cfg (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .raw_nchan (cfg_chan_cnt),
        .raw_delay (cfg_delay),
        .cfg       (cfg_q)
    );

    sdg_pos_track u_pos (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .advance (adv_w),
        .cfg     (cfg_q),
        .pos     (pos_q),
        .keep    (keep_w),
        .last    (last_w)
    );

    sdg_handshake u_hs (
        .start     (start),
        .keep      (keep_w),
        .last      (last_w),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .advance   (adv_w),
        .scan_done (scan_done)
    );

    assign out_data = in_data;

endmodule

// File: rtl/sdg_checker.sv
module sdg_checker
    import sdg_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      start,
    input logic      in_valid,
    input logic      in_ready,
    input logic      out_valid,
    input logic      out_ready,
    input logic      scan_done,
    input gate_cfg_t cfg_q,
    input gate_pos_t pos_q
);

    // R3: a sample that is valid but not offered downstream is absorbed
    p_drop_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !out_valid && !start) |-> in_ready);

    // R9: a stalled forwarded sample holds the input
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R7: the start cycle blocks both sides and clears the position
    p_start_block_r7: assert property (@(posedge clk) disable iff (rst)
        start |-> (!in_ready && !out_valid));
    p_start_clear_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> (pos_q == '0));

    // R6: the position moves only on an accepted sample
    p_pos_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!(in_valid && in_ready) && !start) |=> $stable(pos_q));

    // R8: captured configuration is fixed between starts
    p_cfg_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(cfg_q));

    // R5: with no delay every valid sample is offered
    p_pass_all_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.delay == '0 && in_valid && !start) |-> out_valid);

    // R10: scan completion coincides with an output handshake
    p_done_hs_r10: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> (out_valid && out_ready));

    // R11: captured channel count is always in range
    p_cnt_range_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.nchan != '0) && (cfg_q.nchan <= CNT_W'(CHAN_MAX)));

endmodule

bind scan_decim_gate sdg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .scan_done (scan_done),
    .cfg_q     (cfg_q),
    .pos_q     (pos_q)
);

// File: tb/scan_decim_gate_tb.sv
`timescale 1ns/1ps
module scan_decim_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  cfg_chan_cnt = 5'd1;
    logic [15:0] cfg_delay = 16'd0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = 16'd0;
    logic        out_ready = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_data;
    logic        scan_done;

    int checks = 0;
    int errors = 0;
    int m_n = 1, m_d = 0, m_chan = 0, m_scan = 0;
    int fwd_cnt = 0, done_cnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    scan_decim_gate dut_i (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cfg_chan_cnt (cfg_chan_cnt),
        .cfg_delay    (cfg_delay),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_ready    (out_ready),
        .scan_done    (scan_done)
    );

    function automatic int exp_clamp(input int raw);
        if (raw == 0) return 1;
        if (raw > 16) return 16;
        return raw;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(input bit st, input bit iv, input bit ordy, input string tag);
        bit keep, e_ov, e_ir, acc, e_sd;
        string t;
        @(negedge clk);
        start     = st;
        in_valid  = iv;
        out_ready = ordy;
        in_data   = 16'($urandom);
        #1;
        keep = (m_scan == 0);
        e_ov = iv && keep && !st;
        e_ir = !st && (!keep || ordy);
        acc  = iv && e_ir;
        e_sd = acc && keep && (m_chan == m_n - 1);
        t = st ? "R7" : tag;
        chk(t, "out_valid", 32'(out_valid), 32'(e_ov));
        chk(t, "in_ready", 32'(in_ready), 32'(e_ir));
        chk(st ? "R7" : "R10", "scan_done", 32'(scan_done), 32'(e_sd));
        if (e_ov) chk("R2", "out_data", 32'(out_data), 32'(in_data));
        if (acc && keep) fwd_cnt++;
        if (e_sd) done_cnt++;
        if (st) begin
            m_n = exp_clamp(int'(cfg_chan_cnt));
            m_d = int'(cfg_delay);
            m_chan = 0;
            m_scan = 0;
        end else if (acc) begin
            if (m_chan == m_n - 1) begin
                m_chan = 0;
                m_scan = (m_scan == m_d) ? 0 : m_scan + 1;
            end else begin
                m_chan++;
            end
        end
    endtask

    task automatic run_rand(input int n, input int pv, input int pr, input string tag);
        for (int i = 0; i < n; i++)
            cycle(0, ($urandom % 100) < pv, ($urandom % 100) < pr, tag);
    endtask

    task automatic do_start(input int n, input int d, input string tag);
        cfg_chan_cnt = 5'(n);
        cfg_delay    = 16'(d);
        cycle(1, 1, 1, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state is pass-through
        run_rand(30, 80, 60, "R1");

        // R2, R3, R9: mixed keep/discard with backpressure
        do_start(3, 2, "R3");
        run_rand(300, 70, 60, "R3");
        run_rand(100, 90, 20, "R9");

        // R4: exact chunk accounting, N=2 D=1 over 8 samples
        do_start(2, 1, "R4");
        fwd_cnt = 0;
        done_cnt = 0;
        for (int i = 0; i < 8; i++) cycle(0, 1, 1, "R4");
        chk("R4", "forwarded count", 32'(fwd_cnt), 32'd4);
        chk("R4", "scan_done count", 32'(done_cnt), 32'd2);

        // R5: D=0 passes everything
        do_start(5, 0, "R5");
        run_rand(150, 70, 70, "R5");

        // R6: sparse bursts across chunk boundaries
        do_start(4, 3, "R6");
        run_rand(400, 15, 80, "R6");

        // R8: configuration changes without start are ignored
        do_start(3, 1, "R8");
        run_rand(20, 80, 80, "R8");
        cfg_chan_cnt = 5'd7;
        cfg_delay    = 16'd9;
        run_rand(100, 80, 80, "R8");

        // R7: restart in the middle of a chunk
        do_start(2, 2, "R7");
        for (int i = 0; i < 5; i++) cycle(0, 1, 1, "R7");
        do_start(3, 1, "R7");
        run_rand(60, 80, 80, "R7");

        // R11: channel count clamping and the maximum count
        do_start(0, 2, "R11");
        run_rand(40, 80, 80, "R11");
        do_start(20, 1, "R11");
        run_rand(100, 90, 90, "R11");
        do_start(16, 2, "R11");
        run_rand(150, 90, 70, "R11");

        // R10: random configurations
        for (int k = 0; k < 6; k++) begin
            do_start(1 + ($urandom % 16), $urandom % 6, "R10");
            run_rand(300, 75, 65, "R10");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule